// File: doc/BRIEF.md
# Outbound Address Translation Window Bank

This block turns a local offset into a root complex's outbound memory region into a 64-bit bus address. The outbound region is split into equal power-of-two slices, one slice per window. The upper bits of the offset select the slice. The chosen window's programmed base then supplies the high address bits, and the offset within the slice fills in the low bits. When every window is given a base equal to its own slice start, the result is a direct 1:1 mapping.

Software configures the bank through a small 32-bit register port. A control word holds two independent bits: a link-training enable, which is only passed out on a pin, and a global translation enable. A size word holds the slice size as log2 of megabytes. Each window has a pair of words: a low base word whose bit 0 is that window's enable, and a high word holding the upper 32 address bits. A request is presented for one cycle. The block answers one cycle later with a valid strobe, a hit flag and the translated address.

Top module: `obx_window_bank`

## Requirements
- R1: After reset, every register reads 0, `link_train_en` is 0, and `rsp_valid`, `rsp_hit` and `rsp_addr` are all 0.
- R2: The control word at offset 0x004 keeps bit 0 as the link-training enable, which drives `link_train_en`, and bit 1 as the translation enable. Each bit is written independently of the other. Bits above bit 1 are ignored and read back as 0.
- R3: The size word at offset 0x030 keeps its low 5 bits as the size code, where the slice size is 2^(20+code) bytes. The upper bits are ignored and read back as 0.
- R4: Window n has its low word at 0x200+8n and its high word at 0x204+8n. Both read back exactly as written, including base bits that lie inside the slice. Any other offset reads 0, and writes to it change nothing.
- R5: For a request with offset `o`, the window index is `o >> (20+code)`. On a hit, `rsp_addr` equals {high word, low word with bit 0 cleared}, with the bits below 20+code replaced by the same bits of `o`.
- R6: While control bit 1 is 0, every request returns `rsp_hit`=0 and `rsp_addr`=0.
- R7: A request that selects a window whose low-word bit 0 is 0 returns `rsp_hit`=0 and `rsp_addr`=0.
- R8: A request whose window index is at or above the window count returns `rsp_hit`=0 and `rsp_addr`=0.
- R9: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid`=1. In every other cycle `rsp_hit` and `rsp_addr` are 0.
- R10: A register write accepted at one clock edge already governs a request sampled at the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| req_valid | input | 1 | Translation request strobe |
| req_offset | input | 32 | Offset into the outbound region |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_addr | output | 64 | Translated bus address, 0 on a miss |
| link_train_en | output | 1 | Link-training enable from control bit 0 |

## Verification
Checks in the logic run on every cycle. They confirm that a response strobe follows every request and no other cycle, that a miss always carries a zero address, that nothing hits while translation is off, and that the control word holds its value when it is not written. Some behaviour can only be shown by the bench's scenarios, which compare against a behavioural model. That covers the address arithmetic across several size codes, including codes whose slice is wider than the offset. It also covers disabled windows and out-of-range indices, unaligned bases reading back as written, and writes that are followed in the very next cycle by a request relying on them.

// File: rtl/obx_pkg.sv
package obx_pkg;
  localparam int unsigned MB_SHIFT     = 20;
  localparam int unsigned CTRL_OFS     = 'h004;
  localparam int unsigned SIZE_OFS     = 'h030;
  localparam int unsigned WIN_BASE_OFS = 'h200;
  localparam int unsigned WIN_STRIDE   = 8;
  localparam int unsigned WIN_HI_OFS   = 4;
  localparam int unsigned CTRL_LINK    = 0;
  localparam int unsigned CTRL_XLAT    = 1;
endpackage

// File: rtl/obx_rst_sync.sv
module obx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/obx_regfile.sv
module obx_regfile
  import obx_pkg::*;
#(
  parameter int unsigned NWIN   = 8,
  parameter int unsigned AW     = 12,
  parameter int unsigned SIZE_W = 5
) (
  input  logic                   clk,
  input  logic                   srst_n,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  output logic                   link_en,
  output logic                   xlat_en,
  output logic [SIZE_W-1:0]      size_code,
  output logic [NWIN-1:0][31:0]  win_lo,
  output logic [NWIN-1:0][31:0]  win_hi
);
  logic [1:0]        ctrl_q, ctrl_d;
  logic              ctrl_sel, ctrl_ld;
  logic [SIZE_W-1:0] size_q, size_d;
  logic              size_sel, size_ld;
  logic [NWIN-1:0]   lo_sel, hi_sel, lo_ld, hi_ld;

  // next-state and load enables
  always_comb begin
    ctrl_sel = (addr == AW'(CTRL_OFS));
    size_sel = (addr == AW'(SIZE_OFS));
    ctrl_ld  = we & ctrl_sel;
    size_ld  = we & size_sel;
    ctrl_d   = wdata[1:0];
    size_d   = wdata[SIZE_W-1:0];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl_q <= '0;
      size_q <= '0;
    end else begin
      if (ctrl_ld) ctrl_q <= ctrl_d;
      if (size_ld) size_q <= size_d;
    end
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign lo_sel[g] = (addr == AW'(WIN_BASE_OFS + WIN_STRIDE * g));
    assign hi_sel[g] = (addr == AW'(WIN_BASE_OFS + WIN_STRIDE * g + WIN_HI_OFS));
    assign lo_ld[g]  = we & lo_sel[g];
    assign hi_ld[g]  = we & hi_sel[g];

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) begin
        win_lo[g] <= '0;
        win_hi[g] <= '0;
      end else begin
        if (lo_ld[g]) win_lo[g] <= wdata;
        if (hi_ld[g]) win_hi[g] <= wdata;
      end
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (ctrl_sel) rdata = 32'(ctrl_q);
    if (size_sel) rdata = 32'(size_q);
    for (int n = 0; n < NWIN; n++) begin
      if (lo_sel[n]) rdata = win_lo[n];
      if (hi_sel[n]) rdata = win_hi[n];
    end
  end

  assign link_en   = ctrl_q[CTRL_LINK];
  assign xlat_en   = ctrl_q[CTRL_XLAT];
  assign size_code = size_q;

  // R2: control word holds unless written at its own offset
  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!srst_n)
    !(we && addr == AW'(CTRL_OFS)) |=> $stable(ctrl_q));

  // R10: a write to window 0 low word is visible on the next cycle
  a_r10_lo_visible: assert property (@(posedge clk) disable iff (!srst_n)
    (we && addr == AW'(WIN_BASE_OFS)) |=> (win_lo[0] == $past(wdata)));
endmodule

// File: rtl/obx_xlate.sv
module obx_xlate
  import obx_pkg::*;
#(
  parameter int unsigned NWIN   = 8,
  parameter int unsigned OFS_W  = 32,
  parameter int unsigned SIZE_W = 5
) (
  input  logic                  clk,
  input  logic                  srst_n,
  input  logic                  req_valid,
  input  logic [OFS_W-1:0]      req_offset,
  input  logic                  xlat_en,
  input  logic [SIZE_W-1:0]     size_code,
  input  logic [NWIN-1:0][31:0] win_lo,
  input  logic [NWIN-1:0][31:0] win_hi,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic [63:0]           rsp_addr
);
  localparam int unsigned SHW = 7;

  logic [SHW-1:0] sh;
  logic [63:0]    ofs_w, idx, mask, base, addr_d;
  logic [31:0]    sel_lo, sel_hi;
  logic           in_rng, hit_d;

  // next-state: window select and address merge
  always_comb begin
    sh     = SHW'(MB_SHIFT) + SHW'(size_code);
    ofs_w  = 64'(req_offset);
    idx    = ofs_w >> sh;
    mask   = (64'd1 << sh) - 64'd1;
    sel_lo = '0;
    sel_hi = '0;
    in_rng = 1'b0;
    for (int n = 0; n < NWIN; n++) begin
      if (idx == 64'(n)) begin
        sel_lo = win_lo[n];
        sel_hi = win_hi[n];
        in_rng = 1'b1;
      end
    end
    base   = {sel_hi, sel_lo[31:1], 1'b0};
    hit_d  = req_valid & xlat_en & in_rng & sel_lo[0];
    addr_d = hit_d ? ((base & ~mask) | (ofs_w & mask)) : 64'd0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= hit_d;
      rsp_addr  <= addr_d;
    end
  end

  a_r9_rsp_follows_req: assert property (@(posedge clk) disable iff (!srst_n)
    req_valid |=> rsp_valid);

  a_r9_quiet_no_req: assert property (@(posedge clk) disable iff (!srst_n)
    !req_valid |=> (!rsp_valid && !rsp_hit));

  a_r6_off_misses: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && !xlat_en) |=> !rsp_hit);

  // R7/R8: any miss carries a zero address
  a_r7_miss_zero_addr: assert property (@(posedge clk) disable iff (!srst_n)
    !rsp_hit |-> (rsp_addr == 64'd0));
endmodule

// File: rtl/obx_window_bank.sv
module obx_window_bank #(
  parameter int unsigned NWIN   = 8,
  parameter int unsigned AW     = 12,
  parameter int unsigned OFS_W  = 32,
  parameter int unsigned SIZE_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             req_valid,
  input  logic [OFS_W-1:0] req_offset,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [63:0]      rsp_addr,
  output logic             link_train_en
);
  logic                  srst_n;
  logic                  xlat_en;
  logic [SIZE_W-1:0]     size_code;
  logic [NWIN-1:0][31:0] win_lo, win_hi;

  obx_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  obx_regfile #(.NWIN(NWIN), .AW(AW), .SIZE_W(SIZE_W)) u_regs (
    .clk       (clk),
    .srst_n    (srst_n),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .link_en   (link_train_en),
    .xlat_en   (xlat_en),
    .size_code (size_code),
    .win_lo    (win_lo),
    .win_hi    (win_hi)
  );

  obx_xlate #(.NWIN(NWIN), .OFS_W(OFS_W), .SIZE_W(SIZE_W)) u_xlate (
    .clk        (clk),
    .srst_n     (srst_n),
    .req_valid  (req_valid),
    .req_offset (req_offset),
    .xlat_en    (xlat_en),
    .size_code  (size_code),
    .win_lo     (win_lo),
    .win_hi     (win_hi),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_addr   (rsp_addr)
  );
endmodule

// File: tb/obx_window_bank_tb.sv
module obx_window_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NWIN = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_offset = '0;
  logic        rsp_valid, rsp_hit, link_train_en;
  logic [63:0] rsp_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  obx_window_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_offset(req_offset), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_addr(rsp_addr), .link_train_en(link_train_en)
  );

  // behavioural reference model
  logic [31:0] m_lo [NWIN];
  logic [31:0] m_hi [NWIN];
  logic [4:0]  m_size;
  logic [1:0]  m_ctrl;
  logic [1:0]  m_sync;
  logic        m_wrote;
  logic        e_valid, e_hit;
  logic [63:0] e_addr;
  string       e_tag;

  function automatic logic [64:0] predict(logic [31:0] off);
    int          sh;
    logic [63:0] o, idx, mask, base;
    sh  = 20 + int'(m_size);
    o   = {32'd0, off};
    idx = o >> sh;
    if (!m_ctrl[1] || idx >= 64'(NWIN)) return '0;
    if (!m_lo[int'(idx)][0]) return '0;
    base = {m_hi[int'(idx)], m_lo[int'(idx)] & 32'hFFFF_FFFE};
    mask = (64'd1 << sh) - 64'd1;
    return {1'b1, (base & ~mask) | (o & mask)};
  endfunction

  function automatic string tag_of(logic [31:0] off, logic wrote);
    logic [63:0] idx;
    idx = {32'd0, off} >> (20 + int'(m_size));
    if (wrote) return "R10";
    if (!m_ctrl[1]) return "R6";
    if (idx >= 64'(NWIN)) return "R8";
    if (!m_lo[int'(idx)][0]) return "R7";
    return "R5";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync  <= 2'b00;
      m_size  <= '0;
      m_ctrl  <= '0;
      m_wrote <= 1'b0;
      e_valid <= 1'b0; e_hit <= 1'b0; e_addr <= '0; e_tag <= "R1";
      for (int i = 0; i < NWIN; i++) begin m_lo[i] <= '0; m_hi[i] <= '0; end
    end else begin
      m_sync <= {m_sync[0], 1'b1};
      if (m_sync[1]) begin
        logic [64:0] p;
        p = predict(req_offset);
        e_valid <= req_valid;
        e_hit   <= req_valid & p[64];
        e_addr  <= req_valid ? p[63:0] : 64'd0;
        e_tag   <= req_valid ? tag_of(req_offset, m_wrote) : "R9";
        m_wrote <= reg_we;
        if (reg_we) begin
          if (reg_addr == 12'h004) m_ctrl <= reg_wdata[1:0];
          if (reg_addr == 12'h030) m_size <= reg_wdata[4:0];
          for (int i = 0; i < NWIN; i++) begin
            if (reg_addr == 12'(32'h200 + 8*i)) m_lo[i] <= reg_wdata;
            if (reg_addr == 12'(32'h204 + 8*i)) m_hi[i] <= reg_wdata;
          end
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rsp_valid !== e_valid || rsp_hit !== e_hit || rsp_addr !== e_addr) begin
        fails++;
        $display("FAIL %s: valid/hit/addr got %0b/%0b/%h exp %0b/%0b/%h",
                 e_tag, rsp_valid, rsp_hit, rsp_addr, e_valid, e_hit, e_addr);
      end
      checks++;
      if (link_train_en !== m_ctrl[0]) begin
        fails++;
        $display("FAIL R2: link_train_en got %0b exp %0b", link_train_en, m_ctrl[0]);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; req_valid = 1'b0;
  endtask

  task automatic rq(input logic [31:0] off);
    @(negedge clk);
    reg_we = 1'b0; req_valid = 1'b1; req_offset = off;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_we = 1'b0; req_valid = 1'b0; reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s: read 0x%h got %h exp %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    rd_chk(12'h004, 32'h0, "R1");
    rd_chk(12'h030, 32'h0, "R1");
    rd_chk(12'h200, 32'h0, "R1");
    rd_chk(12'h23C, 32'h0, "R1");
    rq(32'h0);                              // R6: translation off after reset
    // R3: size code, upper bits ignored
    wr(12'h030, 32'hFFFF_FFE3);
    rd_chk(12'h030, 32'h3, "R3");
    // R4: window programming, 8 MB slices
    for (int i = 0; i < NWIN; i++) begin
      wr(12'(32'h200 + 8*i), (32'h8000_0000 + (i << 23)) | ((i == 5) ? 0 : 1));
      wr(12'(32'h204 + 8*i), 32'h10 + i);
    end
    wr(12'h210, 32'h1234_5679);             // unaligned base for window 2
    rd_chk(12'h210, 32'h1234_5679, "R4");
    rd_chk(12'h23C, 32'h17, "R4");
    wr(12'h100, 32'hDEAD_BEEF);             // R4: unmapped write ignored
    wr(12'h240, 32'hCAFE_F00D);
    rd_chk(12'h100, 32'h0, "R4");
    rd_chk(12'h240, 32'h0, "R4");
    rq(32'h0010_0000);                      // R6
    // R2: control bits independent, upper bits ignored
    wr(12'h004, 32'hFFFF_FFF9);
    rd_chk(12'h004, 32'h1, "R2");
    rq(32'h0000_1000);                      // R6 with link enable only
    wr(12'h004, 32'h3);
    rq(32'h0000_0000);                      // R10: enable used next cycle
    rq(32'h007F_FFFF);                      // R5
    rq(32'h0080_0123);                      // R5
    rq(32'h0100_4567);                      // R5 unaligned base
    rq(32'h0281_2345);                      // R7 window 5 disabled
    rq(32'h03FF_FFFF);                      // R5 last window
    rq(32'h0400_0000);                      // R8 index 8
    rq(32'hFFFF_FFFF);                      // R8
    wr(12'h228, 32'h8280_0001);
    rq(32'h0281_2345);                      // R10: window 5 now enabled
    wr(12'h004, 32'h2);                     // R2: link off, translation stays
    rq(32'h0180_0042);
    rd_chk(12'h004, 32'h2, "R2");
    wr(12'h030, 32'h0);                     // 1 MB slices
    rq(32'h0071_2345);                      // R10 / R5 index 7
    rq(32'h0080_0000);                      // R8 index 8
    wr(12'h030, 32'd10);                    // 1 GB slices
    idle_then(32'hC000_1234);               // R5 index 3
    wr(12'h030, 32'd31);                    // slice wider than offset
    idle_then(32'hDEAD_BEEF);               // R5 index 0
    wr(12'h004, 32'h0);
    idle_then(32'h0000_0010);               // R6
    repeat (3) @(negedge clk);
    reg_we = 1'b0; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end

  task automatic idle_then(input logic [31:0] off);
    @(negedge clk);
    reg_we = 1'b0; req_valid = 1'b0;
    rq(off);
  endtask
endmodule